// File: doc/BRIEF.md
# Slow-Tick Timer with Watchdog Mode

This block is a 16-bit counter that advances on a 32.768 kHz tick enable. The tick first passes through a selectable prescaler. Software sets the block up through four word registers on a plain write/read port:

- a control word;
- a load value;
- the live count, which is read-only;
- a clear strobe.

In timer use the counter runs up or down. It either wraps through its full range or reloads from the load value each time it passes its terminal count. Passing the terminal count raises a level interrupt flag.

Setting the watchdog bit turns the same counter into a watchdog. It then always counts down and always reloads on expiry. Expiry produces either a one-cycle reset request or the interrupt flag. Software services the watchdog by writing the clear register. That write reloads the count and restarts the prescaler. Once watchdog mode is on, the control word is frozen until the block is reset.

A control bit lets a peripheral power-down input freeze the counter. Register addresses are: 0 load, 1 count, 2 control, 3 clear.

Top module: `tick_wdog_timer`

## Requirements
- R1: After reset the control word, the count, the load value, `irq` and `rst_req` are all zero.
- R2: A control write stores bits 8:5 and 3:0 of the data. Bits 15:9 and bit 4 always read back as 0.
- R3: When control bit 7 is 0, ticks leave the count unchanged.
- R4: Free-running mode has bit 6 = 0. Counting down, a step from 0x0000 gives 0xFFFF. Counting up, a step from 0xFFFF gives 0x0000. In both cases that step sets `irq`.
- R5: Bit 8 = 1 counts up and bit 8 = 0 counts down, by one per prescaled step.
- R6: Periodic mode has bit 6 = 1. A step taken at the terminal count reloads the load value and sets `irq`. The terminal count is 0x0000 when counting down and 0xFFFF when counting up.
- R7: Bits 3:2 select the prescaler: 00 gives one step per tick, 01 one per 16 ticks, 10 one per 256 ticks, and 11 behaves as 00. The first step falls on the Nth tick after a write to the load or control register.
- R8: A write to the load register stores the value and copies it into the count at once.
- R9: With bit 0 = 1 and `pd_req` high the count holds. With bit 0 = 0 the count keeps stepping while `pd_req` is high.
- R10: `irq` is a level flag. Only a write to the clear register lowers it. Outside watchdog mode that write does not change the count.
- R11: Bit 5 = 1 selects watchdog mode. In it the count always runs down, ignoring bit 8. A step taken at zero reloads the load value. If bit 1 = 0, that step also raises `rst_req` for exactly one cycle.
- R12: In watchdog mode with bit 1 = 1, expiry sets `irq` and never raises `rst_req`.
- R13: Once bit 5 is set, control writes have no effect until reset.
- R14: In watchdog mode a clear write reloads the count from the load value and restarts the prescaler.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | One-cycle pulse per 32.768 kHz period |
| pd_req | input | 1 | Peripheral power-down request |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address (0 load, 2 control, 3 clear) |
| wr_data | input | 16 | Write data |
| rd_addr | input | 2 | Read address (0 load, 1 count, 2 control) |
| rd_data | output | 16 | Read data, combinational from `rd_addr` |
| irq | output | 1 | Interrupt flag (level) |
| rst_req | output | 1 | Watchdog reset request (one-cycle pulse) |

## Verification
The hardest state to reach is a serviced watchdog whose prescaler is partway through a divide-by-16 period. From the ports alone, a restarted prescaler and a free-running one differ only in which later tick produces the next step. The bench first lets the watchdog reach zero with 20 ticks at divide-by-16, so the prescaler is 4 ticks into its next period. It then writes the clear register. It checks that 15 further ticks leave the reloaded count untouched and that the 16th tick moves it. A prescaler that kept running would step after 12 ticks.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

  localparam logic [1:0] ADDR_LOAD  = 2'd0;
  localparam logic [1:0] ADDR_COUNT = 2'd1;
  localparam logic [1:0] ADDR_CTRL  = 2'd2;
  localparam logic [1:0] ADDR_CLEAR = 2'd3;

  // writable control bits: 8:5 and 3:0
  localparam logic [15:0] CTRL_WMASK = 16'h01EF;

  typedef struct packed {
    logic       dir_up;
    logic       run_en;
    logic       periodic;
    logic       wdog;
    logic [1:0] psel;
    logic       wd_irq;
    logic       pd_hold;
  } tmr_cfg_t;

  function automatic tmr_cfg_t decode_ctrl(input logic [15:0] c);
    tmr_cfg_t f;
    f.dir_up   = c[8];
    f.run_en   = c[7];
    f.periodic = c[6];
    f.wdog     = c[5];
    f.psel     = c[3:2];
    f.wd_irq   = c[1];
    f.pd_hold  = c[0];
    return f;
  endfunction

endpackage

// File: rtl/tmr_ctrl_reg.sv
module tmr_ctrl_reg
  import tmr_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_ctrl,
  input  logic [15:0] wr_data,
  output logic [15:0] ctrl_q
);

  logic locked;
  assign locked = ctrl_q[5];

  always_ff @(posedge clk) begin
    if (!rst_n)
      ctrl_q <= '0;
    else if (wr_ctrl && !locked)
      ctrl_q <= wr_data & CTRL_WMASK;
  end

endmodule

// File: rtl/tmr_prescale.sv
module tmr_prescale #(
  parameter int SH_MID = 4,
  parameter int SH_MAX = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       run,
  input  logic       restart,
  input  logic [1:0] psel,
  output logic       step
);

  localparam int DIV_W = SH_MAX;

  logic [DIV_W-1:0] pcnt_q;
  logic [DIV_W-1:0] limit;

  always_comb begin
    case (psel)
      2'b01:   limit = DIV_W'((1 << SH_MID) - 1);
      2'b10:   limit = DIV_W'((1 << SH_MAX) - 1);
      default: limit = '0;
    endcase
  end

  assign step = tick && run && (pcnt_q == limit);

  always_ff @(posedge clk) begin
    if (!rst_n)
      pcnt_q <= '0;
    else if (restart)
      pcnt_q <= '0;
    else if (tick && run)
      pcnt_q <= step ? '0 : pcnt_q + DIV_W'(1);
  end

endmodule

// File: rtl/tmr_count_core.sv
module tmr_count_core #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         step,
  input  logic         dir_up,
  input  logic         periodic,
  input  logic         wdog,
  input  logic         wd_irq,
  input  logic         load_wr,
  input  logic         clear_wr,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] load_q,
  output logic [W-1:0] cnt_q,
  output logic         irq,
  output logic         rst_req
);

  localparam logic [W-1:0] ALL_ONES = '1;

  logic         down;
  logic         reload;
  logic [W-1:0] terminal;
  logic         expire;
  logic [W-1:0] cnt_d;

  assign down     = wdog || !dir_up;
  assign reload   = wdog || periodic;
  assign terminal = down ? '0 : ALL_ONES;
  assign expire   = step && (cnt_q == terminal);

  always_comb begin
    cnt_d = cnt_q;
    if (load_wr)
      cnt_d = wr_data;
    else if (clear_wr && wdog)
      cnt_d = load_q;
    else if (expire)
      cnt_d = reload ? load_q : (down ? ALL_ONES : '0);
    else if (step)
      cnt_d = down ? cnt_q - W'(1) : cnt_q + W'(1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      load_q  <= '0;
      cnt_q   <= '0;
      irq     <= 1'b0;
      rst_req <= 1'b0;
    end else begin
      if (load_wr)
        load_q <= wr_data;
      cnt_q   <= cnt_d;
      rst_req <= expire && wdog && !wd_irq;
      if (expire && !(wdog && !wd_irq))
        irq <= 1'b1;
      else if (clear_wr)
        irq <= 1'b0;
    end
  end

endmodule

// File: rtl/tick_wdog_timer.sv
module tick_wdog_timer
  import tmr_pkg::*;
#(
  parameter int W      = 16,
  parameter int SH_MID = 4,
  parameter int SH_MAX = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick_en,
  input  logic         pd_req,
  input  logic         wr_en,
  input  logic [1:0]   wr_addr,
  input  logic [W-1:0] wr_data,
  input  logic [1:0]   rd_addr,
  output logic [W-1:0] rd_data,
  output logic         irq,
  output logic         rst_req
);

  logic [15:0]  ctrl_q;
  tmr_cfg_t     cfg;
  logic [W-1:0] load_q;
  logic [W-1:0] cnt_q;
  logic         wr_ctrl, wr_load, wr_clear;
  logic         run, step, ps_restart;

  assign cfg      = decode_ctrl(ctrl_q);
  assign wr_ctrl  = wr_en && (wr_addr == ADDR_CTRL);
  assign wr_load  = wr_en && (wr_addr == ADDR_LOAD);
  assign wr_clear = wr_en && (wr_addr == ADDR_CLEAR);

  assign run        = cfg.run_en && !(cfg.pd_hold && pd_req);
  assign ps_restart = wr_ctrl || wr_load || (wr_clear && cfg.wdog);

  tmr_ctrl_reg u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_ctrl (wr_ctrl),
    .wr_data (wr_data[15:0]),
    .ctrl_q  (ctrl_q)
  );

  tmr_prescale #(.SH_MID(SH_MID), .SH_MAX(SH_MAX)) u_ps (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (tick_en),
    .run     (run),
    .restart (ps_restart),
    .psel    (cfg.psel),
    .step    (step)
  );

  tmr_count_core #(.W(W)) u_core (
    .clk      (clk),
    .rst_n    (rst_n),
    .step     (step),
    .dir_up   (cfg.dir_up),
    .periodic (cfg.periodic),
    .wdog     (cfg.wdog),
    .wd_irq   (cfg.wd_irq),
    .load_wr  (wr_load),
    .clear_wr (wr_clear),
    .wr_data  (wr_data),
    .load_q   (load_q),
    .cnt_q    (cnt_q),
    .irq      (irq),
    .rst_req  (rst_req)
  );

  always_comb begin
    case (rd_addr)
      ADDR_LOAD:  rd_data = load_q;
      ADDR_COUNT: rd_data = cnt_q;
      ADDR_CTRL:  rd_data = W'(ctrl_q);
      default:    rd_data = '0;
    endcase
  end

endmodule

// File: rtl/tmr_chk.sv
module tmr_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         wr_en,
  input logic [1:0]   wr_addr,
  input logic [15:0]  ctrl,
  input logic [W-1:0] cnt,
  input logic         pd,
  input logic         irq,
  input logic         rst_req
);

  // R3
  hold_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl[7] && !wr_en) |=> $stable(cnt));

  // R9
  pd_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl[7] && ctrl[0] && pd && !wr_en) |=> $stable(cnt));

  // R10
  irq_clear_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq) |-> $past(wr_en && (wr_addr == 2'd3)));

  // R11
  rst_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |=> !rst_req);

  // R12
  irq_mode_no_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl[5] && ctrl[1]) |-> !rst_req);

  // R13
  ctrl_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl[5] |=> $stable(ctrl));

endmodule

bind tick_wdog_timer tmr_chk #(.W(W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .wr_en   (wr_en),
  .wr_addr (wr_addr),
  .ctrl    (ctrl_q),
  .cnt     (cnt_q),
  .pd      (pd_req),
  .irq     (irq),
  .rst_req (rst_req)
);

// File: tb/test_tick_wdog_timer.sv
module test_tick_wdog_timer;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_en = 1'b0;
  logic        pd_req = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [1:0]  rd_addr = '0;
  logic [15:0] rd_data;
  logic        irq;
  logic        rst_req;

  int vectors = 0;
  int fails = 0;
  int pulses = 0;
  int run_len = 0;
  int max_len = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  tick_wdog_timer i_tick_wdog_timer (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .pd_req(pd_req),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .irq(irq), .rst_req(rst_req)
  );

  always @(negedge clk) begin
    if (rst_req) begin
      pulses++;
      run_len++;
      if (run_len > max_len) max_len = run_len;
    end else begin
      run_len = 0;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s act=0x%0h exp=0x%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    pulses = 0;
    max_len = 0;
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick_en = 1'b1;
      @(negedge clk); tick_en = 1'b0;
    end
  endtask

  task automatic rd(input logic [1:0] a, output int v);
    rd_addr = a;
    #1;
    v = int'(rd_data);
  endtask

  int v;

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    do_reset();
    // R1 reset state
    rd(2'd2, v); chk("R1 ctrl", v, 0);
    rd(2'd1, v); chk("R1 count", v, 0);
    rd(2'd0, v); chk("R1 load", v, 0);
    chk("R1 irq", irq, 0);
    chk("R1 rst_req", rst_req, 0);

    // R2 reserved bits
    wr(2'd2, 16'hFE10); rd(2'd2, v); chk("R2 reserved only", v, 0);
    wr(2'd2, 16'hFFDF); rd(2'd2, v); chk("R2 all but wdog", v, 16'h01CF);

    // R3 disabled counter holds; R8 load copies into count
    wr(2'd2, 16'h0000);
    wr(2'd0, 16'h0007); rd(2'd1, v); chk("R8 load to count", v, 7);
    ticks(5); rd(2'd1, v); chk("R3 hold when off", v, 7);

    // R4/R5 free-running down from 3
    wr(2'd0, 16'h0003); wr(2'd2, 16'h0080);
    for (int s = 1; s <= 8; s++) begin
      ticks(1); rd(2'd1, v); chk("R4 down wrap", v, (3 - s) & 16'hFFFF);
      chk("R4 irq on wrap", irq, s >= 4);
    end
    // R10 clear lowers irq, count untouched
    wr(2'd3, 16'h0000);
    chk("R10 irq cleared", irq, 0);
    rd(2'd1, v); chk("R10 count kept", v, 16'hFFFB);

    // R4/R5 free-running up
    do_reset();
    wr(2'd0, 16'hFFFE); wr(2'd2, 16'h0180);
    for (int s = 1; s <= 5; s++) begin
      ticks(1); rd(2'd1, v); chk("R5 up wrap", v, (16'hFFFE + s) & 16'hFFFF);
      chk("R4 up irq", irq, s >= 2);
    end

    // R6 periodic down, sweep load 0..5
    for (int l = 0; l <= 5; l++) begin
      do_reset();
      wr(2'd0, 16'(l)); wr(2'd2, 16'h00C0);
      for (int s = 1; s <= 14; s++) begin
        ticks(1); rd(2'd1, v);
        chk("R6 periodic down", v, l - (s % (l + 1)));
        chk("R6 periodic irq", irq, s >= l + 1);
      end
    end

    // R6 periodic up, load 0xFFFB
    do_reset();
    wr(2'd0, 16'hFFFB); wr(2'd2, 16'h01C0);
    for (int s = 1; s <= 12; s++) begin
      ticks(1); rd(2'd1, v); chk("R6 periodic up", v, 16'hFFFB + (s % 5));
    end

    // R7 divide by 16
    do_reset();
    wr(2'd0, 16'h1000); wr(2'd2, 16'h0084);
    for (int t = 1; t <= 48; t++) begin
      ticks(1); rd(2'd1, v); chk("R7 div16", v, 16'h1000 - t / 16);
    end
    // R7 divide by 256
    wr(2'd0, 16'h1000); wr(2'd2, 16'h0088);
    ticks(255); rd(2'd1, v); chk("R7 div256 before", v, 16'h1000);
    ticks(1);   rd(2'd1, v); chk("R7 div256 at", v, 16'h0FFF);
    ticks(256); rd(2'd1, v); chk("R7 div256 second", v, 16'h0FFE);
    // R7 setting 11 acts as divide by 1
    wr(2'd0, 16'h1000); wr(2'd2, 16'h008C);
    for (int t = 1; t <= 5; t++) begin
      ticks(1); rd(2'd1, v); chk("R7 psel11", v, 16'h1000 - t);
    end

    // R9 power-down freeze
    do_reset();
    wr(2'd0, 16'd10); wr(2'd2, 16'h0081);
    pd_req = 1'b1; ticks(3); rd(2'd1, v); chk("R9 frozen", v, 10);
    pd_req = 1'b0; ticks(2); rd(2'd1, v); chk("R9 resume", v, 8);
    wr(2'd2, 16'h0080);
    pd_req = 1'b1; ticks(2); rd(2'd1, v); chk("R9 runs in pd", v, 6);
    pd_req = 1'b0;

    // R11 watchdog reset request, direction bit ignored
    do_reset();
    wr(2'd0, 16'd2); wr(2'd2, 16'h01A0);
    rd(2'd2, v); chk("R11 ctrl", v, 16'h01A0);
    ticks(2); rd(2'd1, v); chk("R11 counts down", v, 0);
    chk("R11 no pulse yet", pulses, 0);
    ticks(1); rd(2'd1, v); chk("R11 reload", v, 2);
    chk("R11 one pulse", pulses, 1);
    chk("R11 pulse width", max_len, 1);
    chk("R11 no irq", irq, 0);
    // R13 lock
    wr(2'd2, 16'h0000); rd(2'd2, v); chk("R13 locked", v, 16'h01A0);
    ticks(1); rd(2'd1, v); chk("R13 still runs", v, 1);

    // R12 watchdog interrupt option
    do_reset();
    wr(2'd0, 16'd1); wr(2'd2, 16'h00A2);
    ticks(2);
    chk("R12 irq set", irq, 1);
    chk("R12 no rst", pulses, 0);
    rd(2'd1, v); chk("R12 reload", v, 1);
    wr(2'd3, 16'h0000); chk("R12 irq cleared", irq, 0);

    // R14 service restarts prescaler
    do_reset();
    wr(2'd0, 16'd1); wr(2'd2, 16'h00A4);
    ticks(20); rd(2'd1, v); chk("R14 reached zero", v, 0);
    wr(2'd3, 16'h0000); rd(2'd1, v); chk("R14 reloaded", v, 1);
    ticks(15); rd(2'd1, v); chk("R14 prescaler restarted", v, 1);
    ticks(1);  rd(2'd1, v); chk("R14 step after 16", v, 0);
    chk("R14 no reset", pulses, 0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule